// File: doc/BRIEF.md
# Critical Interrupt Entry Controller

This block decides, once per clock, whether a processor core enters a critical-class interrupt handler. Three sources compete: a level-sensitive critical request line, a watchdog request, and machine checks raised by instruction fetches that earlier failed with a timeout or read error. Each source is gated by an enable bit in the machine state word. A fixed priority picks one winner.

When a source wins, the block saves the return address and the current machine state into a pair of save/restore registers. It then clears every state bit except the machine-check enable, and issues a fetch redirect to the handler. The handler address is built from a prefix and a per-source offset. Machine checks use their own save pair, so a machine check can interrupt a critical handler without losing the critical context.

A fetch error does not raise anything when it is reported. It is remembered against its address and only turns into a machine check when the core tries to execute that address. A return strobe restores the saved state and redirects fetch back to the saved address.

Top module: `critEntryCtl`

## Requirements
- R1: While reset is held and after it, the machine state, all four save registers, the syndrome bit, `redirectValid` and `intCause` read zero.
- R2: A critical interrupt is taken when `critReq` is high and the critical enable (bit 14 of the machine state) is 1, and no machine check is taken in that cycle. One clock later `redirectValid` is 1 and `intCause` is 2. While the enable is 0 the request is not taken.
- R3: A watchdog interrupt needs `wdogReq` and the critical enable bit 14. It loses to the critical request in the same cycle. It reports `intCause` 3 and uses the offset `ivorWdog`.
- R4: The redirect address on entry is `{ivprPrefix, offset, 4'b0000}`, where the offset is `ivorCrit`, `ivorWdog` or `ivorMchk` according to the winning source.
- R5: Critical and watchdog entry load `csrr0Out` with `nextPc` and `csrr1Out` with the machine state as it was before entry.
- R6: On any entry the machine state keeps only its machine-check enable bit 12, and every other bit becomes 0.
- R7: The critical request is level-sensitive. If it is still high when a return re-enables bit 14, a second critical entry follows on the next decision cycle.
- R8: A reported fetch error (`fetchErrValid`, `fetchErrAddr`) is recorded and raises a machine check only in a cycle with `execValid` and a matching `execAddr`. That match sets the sticky `esrMci` bit, which stays 1 until reset.
- R9: A machine check is taken only when bit 12 is 1. With bit 12 at 0 the record is kept and no redirect happens. Once taken, the record is discarded, so a later execution of that address raises nothing.
- R10: A machine check has the highest priority and reports `intCause` 1. It loads `mcsrr0Out` with `execAddr` and `mcsrr1Out` with the prior machine state, and leaves `csrr0Out`/`csrr1Out` unchanged.
- R11: `rfciStrobe` copies `csrr1Out` into the machine state and redirects to `csrr0Out` with `intCause` 0. No interrupt entry is made in that cycle.
- R12: A `msrWrEn` write shows on `msrOut` one clock later, unless an entry or a return happens in the same cycle, in which case the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| critReq | input | 1 | Level-sensitive critical interrupt request |
| wdogReq | input | 1 | Watchdog interrupt request |
| fetchErrValid | input | 1 | An instruction fetch failed (timeout or read error) |
| fetchErrAddr | input | 32 | Address of the failed fetch |
| execValid | input | 1 | An instruction is about to execute |
| execAddr | input | 32 | Address of that instruction |
| nextPc | input | 32 | Address of the next instruction to execute |
| msrWrEn | input | 1 | Software write of the machine state |
| msrWrData | input | 32 | Value to write |
| rfciStrobe | input | 1 | Return from critical interrupt |
| ivprPrefix | input | 16 | Upper bits of every handler address |
| ivorCrit | input | 12 | Handler offset for the critical input |
| ivorWdog | input | 12 | Handler offset for the watchdog |
| ivorMchk | input | 12 | Handler offset for machine checks |
| redirectValid | output | 1 | Fetch redirect this cycle |
| redirectAddr | output | 32 | Redirect target |
| intCause | output | 2 | 0 return/none, 1 machine check, 2 critical, 3 watchdog |
| msrOut | output | 32 | Machine state |
| csrr0Out | output | 32 | Critical saved return address |
| csrr1Out | output | 32 | Critical saved machine state |
| mcsrr0Out | output | 32 | Machine-check saved address |
| mcsrr1Out | output | 32 | Machine-check saved machine state |
| esrMci | output | 1 | Sticky fetch machine-check syndrome bit |

## Verification
Some properties are checked on every cycle: any redirect carrying a cause was preceded by the right request and enable, the state word after entry equals the old word masked to bit 12, the save registers hold the prior address and state, the critical pair stays untouched across a machine check, and a return restores exactly the saved pair. Other behaviour is only visible through the bench's scenarios. These are the re-trigger of a still-asserted level request after a return, and the deferral of a fetch error until its address executes. They also include a record surviving a masked attempt and vanishing after it is taken, and a software write dropped when it collides with entry.

// File: rtl/critEntryPkg.sv
package critEntryPkg;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_MCHK = 2'd1,
    CAUSE_CRIT = 2'd2,
    CAUSE_WDOG = 2'd3
  } causeE;

  typedef struct packed {
    logic takeMchk;
    logic takeCrit;
    logic takeWdog;
    logic doRet;
    logic doMsrWr;
  } ctrlStrbT;

endpackage

// File: rtl/critFetchErrTbl.sv
module critFetchErrTbl #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              logValid,
  input  logic [ADDR_W-1:0] logAddr,
  input  logic              lookValid,
  input  logic [ADDR_W-1:0] lookAddr,
  input  logic              retire,
  output logic              hit
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [ADDR_W-1:0] entAddr [DEPTH];
  logic [DEPTH-1:0]  entValid;
  logic [DEPTH-1:0]  matchVec;
  logic [DEPTH-1:0]  dupVec;
  logic [IDX_W-1:0]  wrPtr;
  logic [IDX_W-1:0]  freeIdx;
  logic [IDX_W-1:0]  slot;
  logic              freeFound;

  for (genvar g = 0; g < DEPTH; g++) begin : gEnt
    assign matchVec[g] = entValid[g] && (entAddr[g] == lookAddr);
    assign dupVec[g]   = entValid[g] && (entAddr[g] == logAddr);
  end

  assign hit = lookValid && (|matchVec);

  always_comb begin
    freeFound = 1'b0;
    freeIdx   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!entValid[i] && !freeFound) begin
        freeFound = 1'b1;
        freeIdx   = IDX_W'(i);
      end
    end
    slot = freeFound ? freeIdx : wrPtr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entValid <= '0;
      wrPtr    <= '0;
      for (int i = 0; i < DEPTH; i++) entAddr[i] <= '0;
    end else begin
      if (retire && lookValid) begin
        for (int i = 0; i < DEPTH; i++) begin
          if (matchVec[i]) entValid[i] <= 1'b0;
        end
      end
      if (logValid && !(|dupVec)) begin
        entValid[slot] <= 1'b1;
        entAddr[slot]  <= logAddr;
        if (!freeFound) begin
          wrPtr <= (wrPtr == IDX_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/critEntryCtrl.sv
module critEntryCtrl
  import critEntryPkg::*;
(
  input  logic     critReq,
  input  logic     wdogReq,
  input  logic     mchkHit,
  input  logic     msrCe,
  input  logic     msrMe,
  input  logic     rfciStrobe,
  input  logic     msrWrEn,
  output ctrlStrbT strb
);
  always_comb begin
    strb = '0;
    if (rfciStrobe) begin
      strb.doRet = 1'b1;
    end else if (mchkHit && msrMe) begin
      strb.takeMchk = 1'b1;
    end else if (critReq && msrCe) begin
      strb.takeCrit = 1'b1;
    end else if (wdogReq && msrCe) begin
      strb.takeWdog = 1'b1;
    end else begin
      strb.doMsrWr = msrWrEn;
    end
  end
endmodule

// File: rtl/critEntryDp.sv
module critEntryDp
  import critEntryPkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MSR_W     = 32,
  parameter int PFX_W     = 16,
  parameter int ME_BIT    = 12,
  parameter int ERR_DEPTH = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrbT                 strb,
  input  logic                     fetchErrValid,
  input  logic [ADDR_W-1:0]        fetchErrAddr,
  input  logic                     execValid,
  input  logic [ADDR_W-1:0]        execAddr,
  input  logic [ADDR_W-1:0]        nextPc,
  input  logic [MSR_W-1:0]         msrWrData,
  input  logic [PFX_W-1:0]         ivprPrefix,
  input  logic [ADDR_W-PFX_W-5:0]  ivorCrit,
  input  logic [ADDR_W-PFX_W-5:0]  ivorWdog,
  input  logic [ADDR_W-PFX_W-5:0]  ivorMchk,
  output logic                     mchkHit,
  output logic                     redirectValid,
  output logic [ADDR_W-1:0]        redirectAddr,
  output logic [1:0]               intCause,
  output logic [MSR_W-1:0]         msrReg,
  output logic [ADDR_W-1:0]        csrr0,
  output logic [MSR_W-1:0]         csrr1,
  output logic [ADDR_W-1:0]        mcsrr0,
  output logic [MSR_W-1:0]         mcsrr1,
  output logic                     esrMci
);
  localparam int OFF_W = ADDR_W - PFX_W - 4;
  localparam logic [MSR_W-1:0] ME_MASK = MSR_W'(1) << ME_BIT;

  logic             anyTake;
  logic [OFF_W-1:0] vecOff;
  logic [ADDR_W-1:0] vecAddr;
  causeE            nextCause;

  critFetchErrTbl #(.ADDR_W(ADDR_W), .DEPTH(ERR_DEPTH)) errTbl_i (
    .clk      (clk),
    .rstN     (rstN),
    .logValid (fetchErrValid),
    .logAddr  (fetchErrAddr),
    .lookValid(execValid),
    .lookAddr (execAddr),
    .retire   (strb.takeMchk),
    .hit      (mchkHit)
  );

  assign anyTake = strb.takeMchk | strb.takeCrit | strb.takeWdog;

  always_comb begin
    if (strb.takeMchk) begin
      vecOff    = ivorMchk;
      nextCause = CAUSE_MCHK;
    end else if (strb.takeWdog) begin
      vecOff    = ivorWdog;
      nextCause = CAUSE_WDOG;
    end else begin
      vecOff    = ivorCrit;
      nextCause = strb.takeCrit ? CAUSE_CRIT : CAUSE_NONE;
    end
    vecAddr = {ivprPrefix, vecOff, 4'b0000};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      redirectValid <= 1'b0;
      redirectAddr  <= '0;
      intCause      <= CAUSE_NONE;
      msrReg        <= '0;
      csrr0         <= '0;
      csrr1         <= '0;
      mcsrr0        <= '0;
      mcsrr1        <= '0;
      esrMci        <= 1'b0;
    end else begin
      redirectValid <= anyTake | strb.doRet;
      redirectAddr  <= strb.doRet ? csrr0 : vecAddr;
      intCause      <= nextCause;
      if (mchkHit) esrMci <= 1'b1;
      if (anyTake) begin
        msrReg <= msrReg & ME_MASK;
      end else if (strb.doRet) begin
        msrReg <= csrr1;
      end else if (strb.doMsrWr) begin
        msrReg <= msrWrData;
      end
      if (strb.takeCrit || strb.takeWdog) begin
        csrr0 <= nextPc;
        csrr1 <= msrReg;
      end
      if (strb.takeMchk) begin
        mcsrr0 <= execAddr;
        mcsrr1 <= msrReg;
      end
    end
  end
endmodule

// File: rtl/critEntryCtl.sv
module critEntryCtl
  import critEntryPkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MSR_W     = 32,
  parameter int PFX_W     = 16,
  parameter int CE_BIT    = 14,
  parameter int ME_BIT    = 12,
  parameter int ERR_DEPTH = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    critReq,
  input  logic                    wdogReq,
  input  logic                    fetchErrValid,
  input  logic [ADDR_W-1:0]       fetchErrAddr,
  input  logic                    execValid,
  input  logic [ADDR_W-1:0]       execAddr,
  input  logic [ADDR_W-1:0]       nextPc,
  input  logic                    msrWrEn,
  input  logic [MSR_W-1:0]        msrWrData,
  input  logic                    rfciStrobe,
  input  logic [PFX_W-1:0]        ivprPrefix,
  input  logic [ADDR_W-PFX_W-5:0] ivorCrit,
  input  logic [ADDR_W-PFX_W-5:0] ivorWdog,
  input  logic [ADDR_W-PFX_W-5:0] ivorMchk,
  output logic                    redirectValid,
  output logic [ADDR_W-1:0]       redirectAddr,
  output logic [1:0]              intCause,
  output logic [MSR_W-1:0]        msrOut,
  output logic [ADDR_W-1:0]       csrr0Out,
  output logic [MSR_W-1:0]        csrr1Out,
  output logic [ADDR_W-1:0]       mcsrr0Out,
  output logic [MSR_W-1:0]        mcsrr1Out,
  output logic                    esrMci
);
  ctrlStrbT strb;
  logic     mchkHit;

  critEntryCtrl ctrl_i (
    .critReq   (critReq),
    .wdogReq   (wdogReq),
    .mchkHit   (mchkHit),
    .msrCe     (msrOut[CE_BIT]),
    .msrMe     (msrOut[ME_BIT]),
    .rfciStrobe(rfciStrobe),
    .msrWrEn   (msrWrEn),
    .strb      (strb)
  );

  critEntryDp #(
    .ADDR_W(ADDR_W), .MSR_W(MSR_W), .PFX_W(PFX_W),
    .ME_BIT(ME_BIT), .ERR_DEPTH(ERR_DEPTH)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .fetchErrValid(fetchErrValid),
    .fetchErrAddr (fetchErrAddr),
    .execValid    (execValid),
    .execAddr     (execAddr),
    .nextPc       (nextPc),
    .msrWrData    (msrWrData),
    .ivprPrefix   (ivprPrefix),
    .ivorCrit     (ivorCrit),
    .ivorWdog     (ivorWdog),
    .ivorMchk     (ivorMchk),
    .mchkHit      (mchkHit),
    .redirectValid(redirectValid),
    .redirectAddr (redirectAddr),
    .intCause     (intCause),
    .msrReg       (msrOut),
    .csrr0        (csrr0Out),
    .csrr1        (csrr1Out),
    .mcsrr0       (mcsrr0Out),
    .mcsrr1       (mcsrr1Out),
    .esrMci       (esrMci)
  );
endmodule

// File: rtl/critEntryChk.sv
module critEntryChk #(
  parameter int ADDR_W = 32,
  parameter int MSR_W  = 32,
  parameter int PFX_W  = 16,
  parameter int CE_BIT = 14,
  parameter int ME_BIT = 12
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    critReq,
  input logic                    wdogReq,
  input logic                    execValid,
  input logic [ADDR_W-1:0]       execAddr,
  input logic [ADDR_W-1:0]       nextPc,
  input logic                    rfciStrobe,
  input logic [PFX_W-1:0]        ivprPrefix,
  input logic [ADDR_W-PFX_W-5:0] ivorCrit,
  input logic                    redirectValid,
  input logic [ADDR_W-1:0]       redirectAddr,
  input logic [1:0]              intCause,
  input logic [MSR_W-1:0]        msrOut,
  input logic [ADDR_W-1:0]       csrr0Out,
  input logic [MSR_W-1:0]        csrr1Out,
  input logic [ADDR_W-1:0]       mcsrr0Out,
  input logic                    esrMci
);
  localparam logic [MSR_W-1:0] ME_MASK = MSR_W'(1) << ME_BIT;

  // R2: a critical entry needs the request and the enable in the deciding cycle
  assert_crit_gated_R2: assert property (@(posedge clk) disable iff (!rstN)
    (redirectValid && intCause == 2'd2) |->
      ($past(critReq) && $past(msrOut[CE_BIT]) && !$past(rfciStrobe)));

  // R3: watchdog needs the enable and loses to the critical request
  assert_wdog_gated_R3: assert property (@(posedge clk) disable iff (!rstN)
    (redirectValid && intCause == 2'd3) |->
      ($past(wdogReq) && $past(msrOut[CE_BIT]) && !$past(critReq)));

  // R4: critical handler address
  assert_crit_vector_R4: assert property (@(posedge clk) disable iff (!rstN)
    (redirectValid && intCause == 2'd2) |->
      (redirectAddr == {$past(ivprPrefix), $past(ivorCrit), 4'b0000}));

  // R5: critical and watchdog save the return address and prior state
  assert_crit_save_R5: assert property (@(posedge clk) disable iff (!rstN)
    (redirectValid && intCause[1]) |->
      (csrr0Out == $past(nextPc) && csrr1Out == $past(msrOut)));

  // R6: entry keeps only the machine-check enable
  assert_msr_entry_R6: assert property (@(posedge clk) disable iff (!rstN)
    (redirectValid && intCause != 2'd0) |->
      (msrOut == ($past(msrOut) & ME_MASK)));

  // R8: syndrome bit is sticky
  assert_mci_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    esrMci |=> esrMci);

  // R9: machine check needs its enable and an executing instruction
  assert_mchk_gated_R9: assert property (@(posedge clk) disable iff (!rstN)
    (redirectValid && intCause == 2'd1) |->
      ($past(msrOut[ME_BIT]) && $past(execValid) && esrMci &&
       mcsrr0Out == $past(execAddr)));

  // R10: machine check leaves the critical pair alone
  assert_mchk_keeps_crit_R10: assert property (@(posedge clk) disable iff (!rstN)
    (redirectValid && intCause == 2'd1) |->
      ($stable(csrr0Out) && $stable(csrr1Out)));

  // R11: return restores the saved pair and makes no entry
  assert_return_restore_R11: assert property (@(posedge clk) disable iff (!rstN)
    rfciStrobe |=>
      (redirectValid && intCause == 2'd0 &&
       redirectAddr == $past(csrr0Out) && msrOut == $past(csrr1Out)));
endmodule

bind critEntryCtl critEntryChk #(
  .ADDR_W(ADDR_W), .MSR_W(MSR_W), .PFX_W(PFX_W), .CE_BIT(CE_BIT), .ME_BIT(ME_BIT)
) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .critReq      (critReq),
  .wdogReq      (wdogReq),
  .execValid    (execValid),
  .execAddr     (execAddr),
  .nextPc       (nextPc),
  .rfciStrobe   (rfciStrobe),
  .ivprPrefix   (ivprPrefix),
  .ivorCrit     (ivorCrit),
  .redirectValid(redirectValid),
  .redirectAddr (redirectAddr),
  .intCause     (intCause),
  .msrOut       (msrOut),
  .csrr0Out     (csrr0Out),
  .csrr1Out     (csrr1Out),
  .mcsrr0Out    (mcsrr0Out),
  .esrMci       (esrMci)
);

// File: tb/critEntryCtl_tb_top.sv
`timescale 1ns/1ps
module critEntryCtl_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        critReq, wdogReq, fetchErrValid, execValid, msrWrEn, rfciStrobe;
  logic [31:0] fetchErrAddr, execAddr, nextPc, msrWrData;
  logic [15:0] ivprPrefix;
  logic [11:0] ivorCrit, ivorWdog, ivorMchk;
  logic        redirectValid;
  logic [31:0] redirectAddr;
  logic [1:0]  intCause;
  logic [31:0] msrOut, csrr0Out, csrr1Out, mcsrr0Out, mcsrr1Out;
  logic        esrMci;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  critEntryCtl dut_i (
    .clk(clk), .rstN(rstN), .critReq(critReq), .wdogReq(wdogReq),
    .fetchErrValid(fetchErrValid), .fetchErrAddr(fetchErrAddr),
    .execValid(execValid), .execAddr(execAddr), .nextPc(nextPc),
    .msrWrEn(msrWrEn), .msrWrData(msrWrData), .rfciStrobe(rfciStrobe),
    .ivprPrefix(ivprPrefix), .ivorCrit(ivorCrit), .ivorWdog(ivorWdog),
    .ivorMchk(ivorMchk), .redirectValid(redirectValid),
    .redirectAddr(redirectAddr), .intCause(intCause), .msrOut(msrOut),
    .csrr0Out(csrr0Out), .csrr1Out(csrr1Out), .mcsrr0Out(mcsrr0Out),
    .mcsrr1Out(mcsrr1Out), .esrMci(esrMci)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    critReq = 0; wdogReq = 0; fetchErrValid = 0; execValid = 0;
    msrWrEn = 0; rfciStrobe = 0;
    fetchErrAddr = '0; execAddr = '0; nextPc = '0; msrWrData = '0;
  endtask

  task automatic doReset();
    idle();
    rstN = 1'b0;
    tick(); tick();
    rstN = 1'b1;
    tick();
  endtask

  task automatic writeMsr(input logic [31:0] v);
    msrWrEn = 1; msrWrData = v;
    tick();
    msrWrEn = 0;
  endtask

  task automatic testReset();
    doReset();
    chk("R1 msr", msrOut, 32'h0);
    chk("R1 redirectValid", {31'b0, redirectValid}, 32'h0);
    chk("R1 cause", {30'b0, intCause}, 32'h0);
    chk("R1 csrr0", csrr0Out, 32'h0);
    chk("R1 mcsrr1", mcsrr1Out, 32'h0);
    chk("R1 esrMci", {31'b0, esrMci}, 32'h0);
  endtask

  task automatic testCritEntry();
    doReset();
    writeMsr(32'h0000_7F0F);
    chk("R12 msr write", msrOut, 32'h0000_7F0F);
    critReq = 1; nextPc = 32'h0000_1234;
    tick();
    chk("R2 redirect", {31'b0, redirectValid}, 32'h1);
    chk("R2 cause", {30'b0, intCause}, 32'h2);
    chk("R4 crit vector", redirectAddr, 32'hFFF0_0100);
    chk("R5 csrr0", csrr0Out, 32'h0000_1234);
    chk("R5 csrr1", csrr1Out, 32'h0000_7F0F);
    chk("R6 msr cleared", msrOut, 32'h0000_1000);
    tick();
    chk("R2 masked by CE", {31'b0, redirectValid}, 32'h0);
    critReq = 0;
  endtask

  task automatic testRetrigger();
    doReset();
    writeMsr(32'h0000_7F0F);
    critReq = 1; nextPc = 32'h0000_1234;
    tick();
    nextPc = 32'h0000_5678; rfciStrobe = 1;
    tick();
    rfciStrobe = 0;
    chk("R11 return cause", {30'b0, intCause}, 32'h0);
    chk("R11 return valid", {31'b0, redirectValid}, 32'h1);
    chk("R11 return addr", redirectAddr, 32'h0000_1234);
    chk("R11 msr restored", msrOut, 32'h0000_7F0F);
    tick();
    chk("R7 retrigger cause", {30'b0, intCause}, 32'h2);
    chk("R7 retrigger csrr0", csrr0Out, 32'h0000_5678);
    critReq = 0;
    tick();
    writeMsr(32'h0000_4000);
    critReq = 1; rfciStrobe = 1;
    tick();
    rfciStrobe = 0;
    chk("R11 no entry with return", {30'b0, intCause}, 32'h0);
    chk("R11 msr from csrr1", msrOut, 32'h0000_7F0F);
    tick();
    chk("R7 entry after return", {30'b0, intCause}, 32'h2);
    critReq = 0;
  endtask

  task automatic testWdog();
    doReset();
    writeMsr(32'h0000_5000);
    wdogReq = 1; nextPc = 32'h0000_0040;
    tick();
    chk("R3 wdog cause", {30'b0, intCause}, 32'h3);
    chk("R4 wdog vector", redirectAddr, 32'hFFF0_0200);
    chk("R5 wdog csrr0", csrr0Out, 32'h0000_0040);
    tick();
    chk("R3 wdog masked", {31'b0, redirectValid}, 32'h0);
    wdogReq = 0;
    doReset();
    writeMsr(32'h0000_5000);
    critReq = 1; wdogReq = 1;
    tick();
    chk("R3 crit beats wdog", {30'b0, intCause}, 32'h2);
    critReq = 0; wdogReq = 0;
    doReset();
    writeMsr(32'h0000_1000);
    wdogReq = 1;
    tick();
    chk("R3 CE off no entry", {31'b0, redirectValid}, 32'h0);
    chk("R3 CE off msr", msrOut, 32'h0000_1000);
    wdogReq = 0;
  endtask

  task automatic testMchk();
    doReset();
    writeMsr(32'h0000_4000);
    fetchErrValid = 1; fetchErrAddr = 32'h0000_2000;
    tick();
    fetchErrValid = 0;
    execValid = 1; execAddr = 32'h0000_3000;
    tick();
    chk("R8 other addr no mchk", {31'b0, redirectValid}, 32'h0);
    chk("R8 other addr no syndrome", {31'b0, esrMci}, 32'h0);
    execAddr = 32'h0000_2000;
    tick();
    chk("R9 ME off no entry", {31'b0, redirectValid}, 32'h0);
    chk("R8 syndrome set", {31'b0, esrMci}, 32'h1);
    execValid = 0;
    writeMsr(32'h0000_5000);
    critReq = 1; nextPc = 32'h0000_1234;
    tick();
    critReq = 0;
    execValid = 1; execAddr = 32'h0000_2000;
    tick();
    chk("R10 mchk cause", {30'b0, intCause}, 32'h1);
    chk("R4 mchk vector", redirectAddr, 32'hFFF0_0300);
    chk("R10 mcsrr0", mcsrr0Out, 32'h0000_2000);
    chk("R10 mcsrr1", mcsrr1Out, 32'h0000_1000);
    chk("R10 csrr0 kept", csrr0Out, 32'h0000_1234);
    chk("R10 csrr1 kept", csrr1Out, 32'h0000_5000);
    tick();
    chk("R9 record discarded", {31'b0, redirectValid}, 32'h0);
    execValid = 0;
    doReset();
    writeMsr(32'h0000_5000);
    fetchErrValid = 1; fetchErrAddr = 32'h0000_2000;
    tick();
    fetchErrValid = 0;
    execValid = 1; execAddr = 32'h0000_2000; critReq = 1;
    tick();
    chk("R10 mchk beats crit", {30'b0, intCause}, 32'h1);
    execValid = 0; critReq = 0;
  endtask

  task automatic testWriteDropped();
    doReset();
    writeMsr(32'h0000_5000);
    critReq = 1; msrWrEn = 1; msrWrData = 32'h0000_FFFF;
    tick();
    msrWrEn = 0; critReq = 0;
    chk("R12 write dropped on entry", msrOut, 32'h0000_1000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    ivprPrefix = 16'hFFF0; ivorCrit = 12'h010; ivorWdog = 12'h020; ivorMchk = 12'h030;
    rstN = 1'b0;
    idle();
    testReset();
    testCritEntry();
    testRetrigger();
    testWdog();
    testMchk();
    testWriteDropped();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule